// File: doc/BRIEF.md
# I2C Master Enable and Abort Sequencer

This block holds the software control word of an I2C master (run enable, transfer abort and command hold) and turns it into orderly sequencing for the bus engine. Software reads and writes a 32-bit control word through a strobed port. The bus engine reports its state on five inputs: idle, end of transfer, end of byte, receive direction and transmit queue empty. From these the block produces several outputs: an effective run flag, a gate that allows command execution, a STOP request, flush strobes for both data queues, a level that holds the queues empty, a request to leave the current received byte unacknowledged, and a one-cycle abort interrupt.

A change of the run enable passes a configurable synchroniser of two stages by default before the sequencer acts on it. The sequencer never stops the bus in mid-flight. On a disable it lets a transmit finish its transfer, or lets a receive finish its byte and NACK it, before it flushes. An abort can only be raised while running and cannot be withdrawn by software. It waits for the transfer in progress, issues STOP together with a transmit flush, raises the interrupt and then clears itself.

Top module: `i2c_enctl`

## Requirements
- R1: The control word reads back run enable at bit 0, abort at bit 1 and command hold at bit 2. Bits 3 to 31 read as zero, and all three live bits are zero after reset.
- R2: The control word changes only in a cycle where the write strobe is high. Write data presented without the strobe leaves the read-back unchanged.
- R3: A write with bit 1 set raises abort only if run enable was already 1 before that write. Otherwise abort stays 0.
- R4: Once abort is 1, writing 0 to bit 1 leaves it at 1. Only the completed abort sequence clears it.
- R5: A pending abort waits for end-of-transfer or engine idle. In the next cycle, STOP request and transmit flush are high together for one cycle. The abort interrupt follows for exactly one cycle, and abort reads 0 one cycle after that.
- R6: The command gate is high only while the block runs steadily, with command hold at 0 and the transmit queue non-empty. It is low during drains, aborts and while disabled.
- R7: After a write that sets run enable, the effective run flag rises on the third clock edge after the write edge, and not before.
- R8: When the block stops, both flush strobes pulse together for one cycle, in the same cycle the effective run flag falls. The queue-hold level stays high for as long as the block is stopped. A disable with the engine idle stops the block on the third edge after the write.
- R9: A disable during a transmit keeps the effective run flag high until end-of-transfer is reported.
- R10: A disable during a receive raises the NACK request and holds it until end-of-byte. End-of-transfer does not end this wait.
- R11: When abort and disable are both pending, the abort sequence runs first and the stop and flush follow once it is done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write value |
| rd_data | output | 32 | Control word read-back |
| eng_idle | input | 1 | Bus engine is idle |
| eng_xfer_done | input | 1 | Current transfer has completed (pulse) |
| eng_byte_done | input | 1 | Current byte has completed (pulse) |
| eng_rx | input | 1 | Engine is receiving |
| txq_empty | input | 1 | Transmit queue is empty |
| run_active | output | 1 | Effective run flag |
| cmd_go | output | 1 | Command execution permitted |
| stop_req | output | 1 | Request a STOP condition |
| txq_flush | output | 1 | Transmit queue flush strobe |
| rxq_flush | output | 1 | Receive queue flush strobe |
| q_hold | output | 1 | Hold both queues empty |
| nack_last | output | 1 | Do not acknowledge the current received byte |
| abort_irq | output | 1 | Abort-complete interrupt pulse |

## Verification
A pending abort and a pending disable can be outstanding at the same time. The bench provokes this by writing abort and then, at once, clearing the enable while the engine stays busy. The read-back must show abort set with the enable cleared, and the run flag must stay high while the abort waits. When the transfer ends, the bench expects STOP with the transmit flush, then the interrupt, then one steady running cycle, then the paired flush with the run flag falling. A second overlap is a software write that tries to clear abort while the hardware sequence is pending; the read-back must keep abort set until the sequence clears it.

// File: rtl/i2c_enctl_pkg.sv
package i2c_enctl_pkg;

    localparam int CW_RUN   = 0;
    localparam int CW_ABORT = 1;
    localparam int CW_HOLD  = 2;
    localparam int CW_LIVE  = 3;

    typedef struct packed {
        logic hold;
        logic abort;
        logic run;
    } ctl_word_t;

    typedef struct packed {
        logic idle;
        logic xfer_done;
        logic byte_done;
        logic rx;
        logic txq_empty;
    } eng_stat_t;

    typedef enum logic [2:0] {
        SQ_OFF,
        SQ_RUN,
        SQ_DRAIN_TX,
        SQ_DRAIN_RX,
        SQ_FLUSH,
        SQ_ABT_WAIT,
        SQ_ABT_STOP,
        SQ_ABT_DONE
    } seq_state_t;

    typedef struct packed {
        logic run_active;
        logic cmd_go;
        logic stop_req;
        logic txq_flush;
        logic rxq_flush;
        logic q_hold;
        logic nack_last;
        logic abort_irq;
        logic abort_clr;
    } seq_out_t;

    function automatic logic [CW_LIVE-1:0] pack_live(input ctl_word_t c);
        logic [CW_LIVE-1:0] v;
        v           = '0;
        v[CW_RUN]   = c.run;
        v[CW_ABORT] = c.abort;
        v[CW_HOLD]  = c.hold;
        return v;
    endfunction

    function automatic logic stop_point(input eng_stat_t e, input logic on_byte);
        return on_byte ? (e.byte_done || e.idle) : (e.xfer_done || e.idle);
    endfunction

endpackage

// File: rtl/enctl_regs.sv
module enctl_regs
    import i2c_enctl_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             abort_clr,
    output ctl_word_t        ctl,
    output logic [REG_W-1:0] rd_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else begin
            if (wr_en) begin
                ctl.run  <= wr_data[CW_RUN];
                ctl.hold <= wr_data[CW_HOLD];
            end
            if (abort_clr) begin
                ctl.abort <= 1'b0;
            end else if (wr_en && wr_data[CW_ABORT] && ctl.run) begin
                ctl.abort <= 1'b1;
            end
        end
    end

    always_comb begin
        rd_data            = '0;
        rd_data[CW_LIVE-1:0] = pack_live(ctl);
    end

    AST_ABORT_GATED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[CW_ABORT] && !ctl.run && !ctl.abort) |=> !ctl.abort); // R3
    AST_ABORT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ctl.abort && !abort_clr) |=> ctl.abort); // R4

endmodule

// File: rtl/enctl_sync.sv
module enctl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    localparam int LAST = STAGES - 1;

    logic [LAST:0] stg;

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= 1'b0;
        else     stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= 1'b0;
            else     stg[i] <= stg[i-1];
        end
    end

    assign q = stg[LAST];

endmodule

// File: rtl/enctl_seq.sv
module enctl_seq
    import i2c_enctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      run_sync,
    input  logic      abort,
    input  logic      hold,
    input  eng_stat_t eng,
    output seq_out_t  o
);

    seq_state_t st, st_nx;

    always_ff @(posedge clk) begin
        if (rst) st <= SQ_OFF;
        else     st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            SQ_OFF:      if (run_sync) st_nx = SQ_RUN;
            SQ_RUN: begin
                if (abort)          st_nx = SQ_ABT_WAIT;
                else if (!run_sync) begin
                    if (eng.idle)    st_nx = SQ_FLUSH;
                    else if (eng.rx) st_nx = SQ_DRAIN_RX;
                    else             st_nx = SQ_DRAIN_TX;
                end
            end
            SQ_DRAIN_TX: if (stop_point(eng, 1'b0)) st_nx = SQ_FLUSH;
            SQ_DRAIN_RX: if (stop_point(eng, 1'b1)) st_nx = SQ_FLUSH;
            SQ_FLUSH:    st_nx = SQ_OFF;
            SQ_ABT_WAIT: if (stop_point(eng, 1'b0)) st_nx = SQ_ABT_STOP;
            SQ_ABT_STOP: st_nx = SQ_ABT_DONE;
            SQ_ABT_DONE: st_nx = SQ_RUN;
            default:     st_nx = SQ_OFF;
        endcase
    end

    always_comb begin
        o            = '0;
        o.run_active = !(st == SQ_OFF || st == SQ_FLUSH);
        o.q_hold     = !o.run_active;
        o.cmd_go     = (st == SQ_RUN) && !hold && !eng.txq_empty;
        o.stop_req   = (st == SQ_ABT_STOP);
        o.txq_flush  = (st == SQ_ABT_STOP) || (st == SQ_FLUSH);
        o.rxq_flush  = (st == SQ_FLUSH);
        o.nack_last  = (st == SQ_DRAIN_RX);
        o.abort_irq  = (st == SQ_ABT_DONE);
        o.abort_clr  = (st == SQ_ABT_DONE);
    end

    AST_STOP_THEN_IRQ: assert property (@(posedge clk) disable iff (rst)
        o.stop_req |=> (o.abort_irq && !o.stop_req)); // R5
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        o.abort_irq |=> !o.abort_irq); // R5
    AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (rst)
        o.rxq_flush |=> (!o.rxq_flush && !o.txq_flush)); // R8
    AST_NACK_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        o.nack_last |-> (o.run_active && !o.cmd_go)); // R10

endmodule

// File: rtl/i2c_enctl.sv
module i2c_enctl
    import i2c_enctl_pkg::*;
#(
    parameter int REG_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             eng_idle,
    input  logic             eng_xfer_done,
    input  logic             eng_byte_done,
    input  logic             eng_rx,
    input  logic             txq_empty,
    output logic             run_active,
    output logic             cmd_go,
    output logic             stop_req,
    output logic             txq_flush,
    output logic             rxq_flush,
    output logic             q_hold,
    output logic             nack_last,
    output logic             abort_irq
);

    ctl_word_t ctl;
    eng_stat_t eng;
    seq_out_t  so;
    logic      run_sync;

    assign eng = '{idle: eng_idle, xfer_done: eng_xfer_done, byte_done: eng_byte_done,
                   rx: eng_rx, txq_empty: txq_empty};

    enctl_regs #(.REG_W(REG_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .abort_clr (so.abort_clr),
        .ctl       (ctl),
        .rd_data   (rd_data)
    );

    enctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ctl.run),
        .q   (run_sync)
    );

    enctl_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .run_sync (run_sync),
        .abort    (ctl.abort),
        .hold     (ctl.hold),
        .eng      (eng),
        .o        (so)
    );

    assign run_active = so.run_active;
    assign cmd_go     = so.cmd_go;
    assign stop_req   = so.stop_req;
    assign txq_flush  = so.txq_flush;
    assign rxq_flush  = so.rxq_flush;
    assign q_hold     = so.q_hold;
    assign nack_last  = so.nack_last;
    assign abort_irq  = so.abort_irq;

    AST_HOLD_GATES_CMD: assert property (@(posedge clk) disable iff (rst)
        ctl.hold |-> !cmd_go); // R6
    AST_STOP_FLUSHES: assert property (@(posedge clk) disable iff (rst)
        $fell(run_active) |-> (rxq_flush && txq_flush && q_hold)); // R8
    AST_ABORT_HELD_TO_IRQ: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl.abort) |-> $past(abort_irq)); // R4

endmodule

// File: tb/tb_i2c_enctl.sv
module tb_i2c_enctl;

    localparam int F_RUN  = 0;
    localparam int F_RD   = 1;
    localparam int F_STOP = 2;
    localparam int F_TXF  = 3;
    localparam int F_RXF  = 4;
    localparam int F_NACK = 5;
    localparam int F_IRQ  = 6;
    localparam int F_GO   = 7;
    localparam int F_HOLD = 8;

    typedef struct {
        int          cyc;
        int          field;
        logic [31:0] val;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        eng_idle = 1'b1, eng_xfer_done = 1'b0, eng_byte_done = 1'b0;
    logic        eng_rx = 1'b0, txq_empty = 1'b1;
    logic        run_active, cmd_go, stop_req, txq_flush, rxq_flush, q_hold, nack_last, abort_irq;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    i2c_enctl dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .eng_idle(eng_idle), .eng_xfer_done(eng_xfer_done), .eng_byte_done(eng_byte_done),
        .eng_rx(eng_rx), .txq_empty(txq_empty), .run_active(run_active), .cmd_go(cmd_go),
        .stop_req(stop_req), .txq_flush(txq_flush), .rxq_flush(rxq_flush), .q_hold(q_hold),
        .nack_last(nack_last), .abort_irq(abort_irq)
    );

    function automatic logic [31:0] probe(input int f);
        case (f)
            F_RUN:  return {31'b0, run_active};
            F_RD:   return rd_data;
            F_STOP: return {31'b0, stop_req};
            F_TXF:  return {31'b0, txq_flush};
            F_RXF:  return {31'b0, rxq_flush};
            F_NACK: return {31'b0, nack_last};
            F_IRQ:  return {31'b0, abort_irq};
            F_GO:   return {31'b0, cmd_go};
            default: return {31'b0, q_hold};
        endcase
    endfunction

    task automatic expect_at(input int dly, input int f, input logic [31:0] v, input string r);
        exp_t e;
        e.cyc = cyc + dly; e.field = f; e.val = v; e.req = r;
        sb.push_back(e);
    endtask

    // monitor: compares queued expectations in their cycle
    always begin
        @(negedge clk);
        #1;
        for (int i = 0; i < sb.size(); ) begin
            if (sb[i].cyc <= cyc) begin
                logic [31:0] a;
                a = probe(sb[i].field);
                n_chk++;
                if (sb[i].cyc < cyc || a !== sb[i].val) begin
                    n_fail++;
                    $display("FAIL %s field %0d cycle %0d: actual %h expected %h",
                             sb[i].req, sb[i].field, sb[i].cyc, a, sb[i].val);
                end
                sb.delete(i);
            end else begin
                i++;
            end
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse_xfer(input logic go_idle);
        @(negedge clk);
        eng_xfer_done = 1'b1;
        if (go_idle) eng_idle = 1'b1;
        @(negedge clk);
        eng_xfer_done = 1'b0;
    endtask

    task automatic pulse_byte();
        @(negedge clk);
        eng_byte_done = 1'b1;
        @(negedge clk);
        eng_byte_done = 1'b0;
    endtask

    task automatic bring_up();
        wr(32'h1);
        wait_cyc(4);
    endtask

    initial begin
        wait_cyc(3);
        rst = 1'b0;

        // R1 reset state
        expect_at(0, F_RD, 32'h0, "R1");
        expect_at(0, F_RUN, 0, "R1");
        expect_at(0, F_HOLD, 1, "R8");
        wait_cyc(1);

        // R3 abort while disabled
        wr(32'h2);
        expect_at(0, F_RD, 32'h0, "R3");
        wait_cyc(1);

        // R7 enable latency, R1 layout
        wr(32'hFFFF_FFF1);
        expect_at(0, F_RD, 32'h1, "R1");
        expect_at(2, F_RUN, 0, "R7");
        expect_at(3, F_RUN, 1, "R7");
        expect_at(3, F_HOLD, 0, "R8");
        wait_cyc(4);

        // R2 data without strobe
        @(negedge clk); wr_data = 32'h6;
        expect_at(1, F_RD, 32'h1, "R2");
        wait_cyc(2); wr_data = '0;

        // R6 command gate
        @(negedge clk); txq_empty = 1'b0;
        expect_at(0, F_GO, 1, "R6");
        wr(32'h5);
        expect_at(0, F_GO, 0, "R6");
        expect_at(0, F_RD, 32'h5, "R1");
        wr(32'h1);
        expect_at(0, F_GO, 1, "R6");
        @(negedge clk); txq_empty = 1'b1;
        expect_at(0, F_GO, 0, "R6");
        @(negedge clk); txq_empty = 1'b0;

        // R4/R5 abort sequence with engine busy
        eng_idle = 1'b0;
        wr(32'h3);
        expect_at(0, F_RD, 32'h3, "R3");
        expect_at(1, F_GO, 0, "R6");
        wr(32'h1);
        expect_at(0, F_RD, 32'h3, "R4");
        expect_at(0, F_STOP, 0, "R5");
        wait_cyc(3);
        pulse_xfer(1'b0);
        expect_at(0, F_STOP, 1, "R5");
        expect_at(0, F_TXF, 1, "R5");
        expect_at(0, F_RXF, 0, "R5");
        expect_at(0, F_RD, 32'h3, "R4");
        expect_at(1, F_IRQ, 1, "R5");
        expect_at(1, F_STOP, 0, "R5");
        expect_at(2, F_IRQ, 0, "R5");
        expect_at(2, F_RD, 32'h1, "R5");
        wait_cyc(4);

        // R9 disable while transmitting
        wr(32'h0);
        expect_at(0, F_RD, 32'h0, "R9");
        expect_at(3, F_RUN, 1, "R9");
        expect_at(3, F_GO, 0, "R6");
        expect_at(3, F_TXF, 0, "R9");
        wait_cyc(6);
        expect_at(0, F_RUN, 1, "R9");
        pulse_xfer(1'b0);
        expect_at(0, F_TXF, 1, "R8");
        expect_at(0, F_RXF, 1, "R8");
        expect_at(0, F_RUN, 0, "R9");
        expect_at(1, F_TXF, 0, "R8");
        expect_at(1, F_HOLD, 1, "R8");
        wait_cyc(3);

        // R10 disable while receiving
        bring_up();
        eng_rx = 1'b1;
        wr(32'h0);
        expect_at(2, F_NACK, 0, "R10");
        expect_at(3, F_NACK, 1, "R10");
        wait_cyc(4);
        pulse_xfer(1'b0);
        expect_at(0, F_NACK, 1, "R10");
        expect_at(0, F_RXF, 0, "R10");
        pulse_byte();
        expect_at(0, F_NACK, 0, "R10");
        expect_at(0, F_RXF, 1, "R10");
        expect_at(0, F_TXF, 1, "R8");
        wait_cyc(3);
        eng_rx = 1'b0;

        // R8 disable while idle
        eng_idle = 1'b1;
        bring_up();
        wr(32'h0);
        expect_at(2, F_RUN, 1, "R8");
        expect_at(3, F_RUN, 0, "R8");
        expect_at(3, F_RXF, 1, "R8");
        expect_at(4, F_RXF, 0, "R8");
        expect_at(4, F_HOLD, 1, "R8");
        wait_cyc(8);
        expect_at(0, F_HOLD, 1, "R8");

        // R11 abort and disable pending together
        bring_up();
        eng_idle = 1'b0;
        wr(32'h3);
        wr(32'h0);
        expect_at(0, F_RD, 32'h2, "R11");
        wait_cyc(6);
        expect_at(0, F_RUN, 1, "R11");
        expect_at(0, F_RXF, 0, "R11");
        pulse_xfer(1'b1);
        expect_at(0, F_STOP, 1, "R11");
        expect_at(0, F_RXF, 0, "R11");
        expect_at(1, F_IRQ, 1, "R11");
        expect_at(2, F_RUN, 1, "R11");
        expect_at(2, F_RD, 32'h0, "R11");
        expect_at(3, F_RUN, 0, "R11");
        expect_at(3, F_TXF, 1, "R11");
        expect_at(3, F_RXF, 1, "R11");
        wait_cyc(6);

        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        if (sb.size() != 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule